// File: doc/BRIEF.md
# Alternating-Phase Pipeline Memory Scheduler

This block sequences a four-stage in-order processor pipeline (fetch, decode, execute, and a combined memory-access plus register write-back stage). All four stages share one single-port memory for instructions and data in one address space. A phase register alternates between even and odd cycles. Fetch and execute are enabled on even cycles. Decode and memory/write-back are enabled on odd cycles. Because of this split, an instruction fetch and a data access can never want the memory port in the same cycle, and no stall logic is needed.

On even cycles the block drives the program counter onto the memory port as a read. On odd cycles it offers the port to the memory stage through a valid/ready request channel. A request is taken when `dreq_valid` and `dreq_ready` are both high. `dreq_ready` is high only on odd, non-held cycles. A requester that sees `dreq_ready` low must hold its request stable until it is taken. The memory returns read data one cycle after a read. The block tags each read with its phase and steers the returned word into an instruction register or a load-result register. The memory has no back-pressure: it must accept a request in every cycle.

A `hold` input freezes the pipeline so that an external loader can own the memory port. When hold is released, the program counter restarts from `start_addr` on an even phase.

Top module: `phase_mem_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) has these effects in the first cycle after it: the phase is even, `stage_vld` is 0, `instr_vld` and `load_vld` are 0, and the fetch address on `mem_addr` is the parameter `RESET_VEC` (default 16'h0100).
- R2: On an even, non-held cycle, `stage_en` is 4'b0101 (bit 0 is fetch, bit 2 is execute). The port carries `mem_addr` equal to the PC, `mem_re`=1, `mem_we`=0 and `mem_be` all ones, and `fetch_req`=1.
- R3: On an odd, non-held cycle, `stage_en` is 4'b1010 (bit 1 is decode, bit 3 is memory/write-back) and `dreq_ready`=1. The port carries `dreq_addr` and `dreq_be`. `mem_re` equals `dreq_valid & ~dreq_we`, and `mem_we` equals `dreq_valid & dreq_we`.
- R4: `fetch_req` and an accepted data request (`dreq_valid & dreq_ready`) are never high in the same cycle. Away from hold, `stage_en` alternates between the two patterns of R2 and R3 every cycle.
- R5: After each fetch, the PC becomes PC+4. If `br_take` is high in the fetch cycle, the PC becomes `br_target` instead.
- R6: Read data present on `mem_rdata` in the cycle after a read is registered at the end of that cycle. It appears on `instr_q`, with `instr_vld` high for one cycle, if the read was a fetch (even phase). It appears on `load_q`, with `load_vld` high for one cycle, if the read was a data read (odd phase).
- R7: A data write, an idle odd cycle, or a held cycle produces no capture: two cycles later, both `instr_vld` and `load_vld` are 0.
- R8: While `hold` is high, the following apply. `stage_en`=0, `fetch_req`=0, `dreq_ready`=0 and `mem_re`=0. The port carries `ld_addr` and `ld_wdata`, with `mem_we`=`ld_we` and `mem_be` all ones. Data requests are ignored. `stage_vld` reads 0 from the cycle after hold is first seen.
- R9: In the first cycle after `hold` falls, the phase is even and the fetch address equals `start_addr` as sampled in the last held cycle. The next cycle is odd.
- R10: `stage_vld` fills as a thermometer after reset or hold: 0000, 0001, 0011, 0111, then 1111 in successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freeze pipeline; loader owns memory port |
| start_addr | input | AW | PC loaded while held, used on release |
| br_take | input | 1 | Redirect the PC in the current fetch cycle |
| br_target | input | AW | Redirect target |
| stage_en | output | 4 | Per-stage enables (fetch, decode, execute, mem/wb) |
| stage_vld | output | 4 | Per-stage occupancy bits |
| fetch_req | output | 1 | Fetch read is on the port this cycle |
| dreq_valid | input | 1 | Memory-stage request valid |
| dreq_ready | output | 1 | Port offered to the memory stage |
| dreq_we | input | 1 | Request is a write |
| dreq_addr | input | AW | Data address |
| dreq_be | input | DW/8 | Data byte enables |
| dreq_wdata | input | DW | Store data |
| ld_addr | input | AW | Loader address |
| ld_wdata | input | DW | Loader write data |
| ld_we | input | 1 | Loader write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte enables |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Read data, one cycle after the read |
| instr_q | output | DW | Captured instruction word |
| instr_vld | output | 1 | Pulse: `instr_q` updated |
| load_q | output | DW | Captured load result |
| load_vld | output | 1 | Pulse: `load_q` updated |

## Verification
A phase register that stalls or flips twice shows at once: `stage_en` repeats a pattern or `fetch_req` coincides with `dreq_ready`, and the per-cycle monitor catches this in the same cycle. A wrong read tag sends the word to the wrong capture register. That error is seen exactly two cycles after the read. A broken occupancy shift breaks the thermometer fill within four cycles of reset or hold release. A PC that is not reloaded shows on `mem_addr` in the first cycle after release.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

  localparam int NSTG   = 4;
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MW  = 3;
endpackage

// File: rtl/pms_phase.sv
module pms_phase
  import pms_pkg::*;
#(
  parameter int N = NSTG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output phase_e       phase,
  output logic [N-1:0] en,
  output logic [N-1:0] vld
);

  always_ff @(posedge clk) begin
    if (rst || hold) phase <= PH_EVEN;
    else             phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign en[k] = !hold && (phase == (((k % 2) == 0) ? PH_EVEN : PH_ODD));
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || hold) vld[k] <= 1'b0;
        else if (en[k])  vld[k] <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || hold) vld[k] <= 1'b0;
        else if (en[k])  vld[k] <= vld[k-1];
      end
    end
  end

  // R4: enable pattern flips every unheld cycle
  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    (!hold && !$past(hold) && !$past(rst)) |-> (en != $past(en)));

  // R10: occupancy is always a thermometer code
  a_r10_thermo: assert property (@(posedge clk) disable iff (rst)
    (((vld + N'(1)) & vld) == '0));

endmodule

// File: rtl/pms_port_mux.sv
module pms_port_mux
  import pms_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          hold,
  input  phase_e        phase,
  input  logic [AW-1:0] pc,
  input  logic          dreq_valid,
  input  logic          dreq_we,
  input  logic [AW-1:0] dreq_addr,
  input  logic [BW-1:0] dreq_be,
  input  logic [DW-1:0] dreq_wdata,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic          ld_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [BW-1:0] mem_be,
  output logic          mem_re,
  output logic          mem_we
);

  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_be    = '1;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    if (hold) begin
      mem_addr  = ld_addr;
      mem_wdata = ld_wdata;
      mem_we    = ld_we;
    end else if (phase == PH_EVEN) begin
      mem_re    = 1'b1;
    end else begin
      mem_addr  = dreq_addr;
      mem_wdata = dreq_wdata;
      mem_be    = dreq_be;
      mem_re    = dreq_valid && !dreq_we;
      mem_we    = dreq_valid && dreq_we;
    end
  end

endmodule

// File: rtl/pms_rd_steer.sv
module pms_rd_steer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_rd,
  input  logic          load_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] instr_q,
  output logic          instr_vld,
  output logic [DW-1:0] load_q,
  output logic          load_vld
);

  logic tag_f, tag_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_f     <= 1'b0;
      tag_l     <= 1'b0;
      instr_vld <= 1'b0;
      load_vld  <= 1'b0;
      instr_q   <= '0;
      load_q    <= '0;
    end else begin
      tag_f     <= fetch_rd;
      tag_l     <= load_rd;
      instr_vld <= tag_f;
      load_vld  <= tag_l;
      if (tag_f) instr_q <= mem_rdata;
      if (tag_l) load_q  <= mem_rdata;
    end
  end

  // R6: a fetch read lands in the instruction register two cycles on
  a_r6_fetch_dest: assert property (@(posedge clk) disable iff (rst)
    fetch_rd |-> ##2 (instr_vld && !load_vld));

  // R6: a data read lands in the load register two cycles on
  a_r6_load_dest: assert property (@(posedge clk) disable iff (rst)
    load_rd |-> ##2 (load_vld && !instr_vld));

  // R7: no read, no capture
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!fetch_rd && !load_rd) |-> ##2 (!instr_vld && !load_vld));

endmodule

// File: rtl/phase_mem_sched.sv
module phase_mem_sched
  import pms_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter logic [15:0] RESET_VEC = 16'h0100,
  localparam int         BW        = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] start_addr,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  output logic [3:0]    stage_en,
  output logic [3:0]    stage_vld,
  output logic          fetch_req,
  input  logic          dreq_valid,
  output logic          dreq_ready,
  input  logic          dreq_we,
  input  logic [AW-1:0] dreq_addr,
  input  logic [BW-1:0] dreq_be,
  input  logic [DW-1:0] dreq_wdata,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic          ld_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [BW-1:0] mem_be,
  output logic          mem_re,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] instr_q,
  output logic          instr_vld,
  output logic [DW-1:0] load_q,
  output logic          load_vld
);

  phase_e        phase;
  logic [AW-1:0] pc_q;

  pms_phase #(.N(NSTG)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold),
    .phase (phase),
    .en    (stage_en),
    .vld   (stage_vld)
  );

  assign fetch_req  = stage_en[ST_IF];
  assign dreq_ready = stage_en[ST_MW];

  always_ff @(posedge clk) begin
    if (rst)            pc_q <= AW'(RESET_VEC);
    else if (hold)      pc_q <= start_addr;
    else if (fetch_req) pc_q <= br_take ? br_target : pc_q + AW'(4);
  end

  pms_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .hold       (hold),
    .phase      (phase),
    .pc         (pc_q),
    .dreq_valid (dreq_valid),
    .dreq_we    (dreq_we),
    .dreq_addr  (dreq_addr),
    .dreq_be    (dreq_be),
    .dreq_wdata (dreq_wdata),
    .ld_addr    (ld_addr),
    .ld_wdata   (ld_wdata),
    .ld_we      (ld_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .mem_re     (mem_re),
    .mem_we     (mem_we)
  );

  pms_rd_steer #(.DW(DW)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .fetch_rd  (mem_re && fetch_req),
    .load_rd   (mem_re && dreq_ready),
    .mem_rdata (mem_rdata),
    .instr_q   (instr_q),
    .instr_vld (instr_vld),
    .load_q    (load_q),
    .load_vld  (load_vld)
  );

  // R4: fetch and data access never share a cycle
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && dreq_valid && dreq_ready));

  // R8: held cycles leave the port to the loader only
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold |-> (stage_en == '0 && !mem_re && !dreq_ready && mem_addr == ld_addr));

  // R9: release resumes with an even fetch from the start address
  a_r9_resume: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(hold)) |-> (fetch_req && mem_addr == $past(start_addr)));

  // R5: sequential fetches step the address by one word
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !hold && !$past(hold) && !$past(hold, 2) && !$past(rst)
     && !$past(rst, 2) && $past(fetch_req, 2) && !$past(br_take, 2))
    |-> (mem_addr == $past(mem_addr, 2) + AW'(4)));

endmodule

// File: tb/sim_phase_mem_sched.sv
module sim_phase_mem_sched;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hold = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          br_take = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [3:0]    stage_en, stage_vld;
  logic          fetch_req, dreq_ready;
  logic          dreq_valid = 1'b0, dreq_we = 1'b0;
  logic [AW-1:0] dreq_addr = '0;
  logic [BW-1:0] dreq_be = 4'h3;
  logic [DW-1:0] dreq_wdata = 32'h55;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_wdata = '0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [BW-1:0] mem_be;
  logic          mem_re, mem_we;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] instr_q, load_q;
  logic          instr_vld, load_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phase_mem_sched #(.AW(AW), .DW(DW), .RESET_VEC(16'h0100)) u0 (
    .clk(clk), .rst(rst), .hold(hold), .start_addr(start_addr),
    .br_take(br_take), .br_target(br_target), .stage_en(stage_en),
    .stage_vld(stage_vld), .fetch_req(fetch_req), .dreq_valid(dreq_valid),
    .dreq_ready(dreq_ready), .dreq_we(dreq_we), .dreq_addr(dreq_addr),
    .dreq_be(dreq_be), .dreq_wdata(dreq_wdata), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .ld_we(ld_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_re(mem_re), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .instr_q(instr_q), .instr_vld(instr_vld),
    .load_q(load_q), .load_vld(load_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {exp_vld[3:0], dv, dwe, exp_en[3:0], exp_re, exp_we, addr[15:0]}
  localparam logic [27:0] VEC [8] = '{
    {4'b0000, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 16'h0100},
    {4'b0001, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b0, 16'h0800},
    {4'b0011, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 16'h0104},
    {4'b0111, 1'b1, 1'b1, 4'b1010, 1'b0, 1'b1, 16'h0804},
    {4'b1111, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 16'h0108},
    {4'b1111, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b0, 16'h0808},
    {4'b1111, 1'b0, 1'b0, 4'b0101, 1'b1, 1'b0, 16'h010C},
    {4'b1111, 1'b1, 1'b0, 4'b1010, 1'b1, 1'b0, 16'h080C}
  };

  // R4 monitor: every unheld cycle, mutual exclusion and pattern
  always begin
    @(negedge clk);
    #5;
    if (!rst && !hold && !done) begin
      chk("R4 exclusive", {30'd0, fetch_req, dreq_ready}, {30'd0, fetch_req, !fetch_req});
      chk("R4 pattern", {28'd0, stage_en}, fetch_req ? 32'h5 : 32'hA);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) rst = 1'b0;
      dreq_valid = VEC[k][23];
      dreq_we    = VEC[k][22];
      dreq_addr  = VEC[k][15:0];
      mem_rdata  = 32'hA000_0000 | 32'(k);
      #1;
      if (k == 0) begin
        chk("R1 reset vld", {28'd0, stage_vld}, 32'h0);
        chk("R1 reset capture", {30'd0, instr_vld, load_vld}, 32'h0);
        chk("R1 reset vector", {16'd0, mem_addr}, 32'h0100);
      end
      chk((k % 2 == 0) ? "R2 even enables" : "R3 odd enables", {28'd0, stage_en}, {28'd0, VEC[k][21:18]});
      chk("R2/R3 mem_re", {31'd0, mem_re}, {31'd0, VEC[k][17]});
      chk("R3 mem_we", {31'd0, mem_we}, {31'd0, VEC[k][16]});
      chk("R2/R3 mem_addr", {16'd0, mem_addr}, {16'd0, VEC[k][15:0]});
      chk("R2/R3 mem_be", {28'd0, mem_be}, (k % 2 == 0) ? 32'hF : 32'h3);
      chk("R10 thermometer", {28'd0, stage_vld}, {28'd0, VEC[k][27:24]});
      if (k >= 2) begin
        if (VEC[k-2][17] && ((k - 2) % 2 == 0)) begin
          chk("R6 fetch capture", {31'd0, instr_vld}, 32'h1);
          chk("R6 instr data", instr_q, 32'hA000_0000 | 32'(k - 1));
          chk("R6 no load", {31'd0, load_vld}, 32'h0);
        end else if (VEC[k-2][17]) begin
          chk("R6 load capture", {31'd0, load_vld}, 32'h1);
          chk("R6 load data", load_q, 32'hA000_0000 | 32'(k - 1));
          chk("R6 no instr", {31'd0, instr_vld}, 32'h0);
        end else begin
          chk("R7 no capture", {30'd0, instr_vld, load_vld}, 32'h0);
        end
      end
    end
    // R5: redirect on a fetch cycle
    @(negedge clk); dreq_valid = 1'b0; br_take = 1'b1; br_target = 16'h0200; #1;
    chk("R5 seq fetch", {16'd0, mem_addr}, 32'h0110);
    @(negedge clk); br_take = 1'b0;
    @(negedge clk); #1;
    chk("R5 redirect", {16'd0, mem_addr}, 32'h0200);
    @(negedge clk);
    @(negedge clk); #1;
    chk("R5 after redirect", {16'd0, mem_addr}, 32'h0204);
    // R8: hold hands the port to the loader; data requests ignored
    @(negedge clk);
    hold = 1'b1; ld_addr = 16'h0AAA; ld_wdata = 32'h1234; ld_we = 1'b1;
    dreq_valid = 1'b1; dreq_we = 1'b1; start_addr = 16'h0300; #1;
    chk("R8 enables off", {28'd0, stage_en}, 32'h0);
    chk("R8 no ready/fetch", {30'd0, dreq_ready, fetch_req}, 32'h0);
    chk("R8 port", {mem_addr, 8'd0, mem_re, mem_we, 2'd0, mem_be}, {16'h0AAA, 8'd0, 1'b0, 1'b1, 2'd0, 4'hF});
    chk("R8 wdata", mem_wdata, 32'h1234);
    @(negedge clk); #1;
    chk("R8 vld cleared", {28'd0, stage_vld}, 32'h0);
    @(negedge clk); hold = 1'b0; dreq_valid = 1'b0; #1;
    chk("R9 resume fetch", {15'd0, fetch_req, mem_addr}, {15'd0, 1'b1, 16'h0300});
    chk("R9 even enables", {28'd0, stage_en}, 32'h5);
    chk("R9 loader released", {31'd0, mem_we}, 32'h0);
    chk("R8 no read in hold", {30'd0, instr_vld, load_vld}, 32'h0);
    @(negedge clk); #1;
    chk("R9 then odd", {27'd0, stage_en, dreq_ready}, {27'd0, 4'hA, 1'b1});
    @(negedge clk); #1;
    chk("R5 after resume", {16'd0, mem_addr}, 32'h0304);
    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 rerun vld", {28'd0, stage_vld}, 32'h0);
    chk("R1 rerun vector", {16'd0, mem_addr}, 32'h0100);
    chk("R1 rerun phase", {28'd0, stage_en}, 32'h5);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule